// File: doc/BRIEF.md
# Ethernet DMA frame buffer formatter

The block sits between a MAC byte stream and the byte streams that a DMA engine moves into and out of descriptor buffers. On the receive side it takes a complete frame from the MAC into a local store. It then emits a buffer image: a two-byte little-endian length prefix, the frame bytes, and zero fill up to a four-byte aligned size. A later request on the same stream emits a status phase made of an optional checksum word and the receive status word. On the transmit side it reads a two-byte length prefix from the DMA stream and forwards exactly that many bytes to the MAC. A later request returns the four-byte transmit status word on a separate completion stream.

Every request is a one-cycle start pulse while the path is idle. Receive and transmit each keep a one-bit phase register. It picks whether the next start opens a frame phase or a status phase, and it resets to the frame phase. Status and sticky words are driven out as ports. Sticky bits only accumulate, and reset is the only thing that clears them. Line coding, CRC generation and the DMA engine itself sit outside the block. The checksum word is taken from an input.

Top module: `eth_dmabuf_fmt`

## Requirements
- R1: In a receive frame phase the first two buffer bytes carry the reported length, low byte first. The reported length is the stored byte count plus 8, with a floor of 64.
- R2: After the prefix the stored frame bytes follow in arrival order. Zero bytes follow them until the bytes after the prefix number the reported length rounded up to a multiple of 4. `rx_buf_last` marks the final byte.
- R3: A start pulse that would open a frame phase while the matching enable (`rx_en` or `tx_en`) is low is ignored. No bytes move and busy stays low.
- R4: When the last receive buffer byte is accepted, the receive status bits [15:0] take the reported length. Bit 16 (accept) and bit 17 (complete) are set in both the status and sticky words.
- R5: A receive status phase sets bit 18 (ok) in status and sticky. It then emits the status word, low byte first. When checksum mode is on, the four checksum bytes from `rx_crc_in` come first, also low byte first. The final byte carries `rx_buf_last`.
- R6: The receive path alternates frame phase and status phase on successive accepted starts, and reset leaves it in the frame phase. The transmit path does the same, but only a non-zero-length frame moves it to the status phase.
- R7: Receive bytes beyond `CAP_BYTES` are consumed from the MAC but dropped. Status bit 19 (overflow) is loaded with this flag at frame end and is also set in sticky.
- R8: A transmit length prefix of zero ends the request. No byte reaches the MAC, and the status, the sticky word and the phase stay unchanged.
- R9: A non-zero prefix forwards exactly that many following bytes to the MAC, with `tx_mac_last` on the final one. Transmit bit 0 (complete) is then set in status and sticky.
- R10: A transmit status phase sets bit 1 (ok) in status and sticky. It then emits the four status bytes, low byte first, on the completion stream.
- R11: A rising edge of an enable clears that path's complete bit in its status word. The sticky word is left as it was.
- R12: After reset both status and sticky words are zero, both paths are idle, and no output stream is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| cks_mode | input | 1 | Emit checksum word in receive status phase |
| rx_crc_in | input | 32 | Checksum word to emit |
| rx_start | input | 1 | Receive request pulse |
| rx_busy | output | 1 | Receive request in progress |
| rx_mac_valid | input | 1 | MAC receive byte valid |
| rx_mac_data | input | 8 | MAC receive byte |
| rx_mac_last | input | 1 | Last byte of the MAC frame |
| rx_mac_ready | output | 1 | Block accepts MAC byte |
| rx_buf_valid | output | 1 | Receive buffer byte valid |
| rx_buf_data | output | 8 | Receive buffer byte |
| rx_buf_last | output | 1 | Final byte of the phase |
| rx_buf_ready | input | 1 | DMA accepts buffer byte |
| rx_status | output | 32 | Receive status word |
| rx_sticky | output | 32 | Receive sticky word |
| tx_en | input | 1 | Transmit enable |
| tx_start | input | 1 | Transmit request pulse |
| tx_busy | output | 1 | Transmit request in progress |
| tx_buf_valid | input | 1 | DMA transmit byte valid |
| tx_buf_data | input | 8 | DMA transmit byte |
| tx_buf_ready | output | 1 | Block accepts DMA byte |
| tx_mac_valid | output | 1 | MAC transmit byte valid |
| tx_mac_data | output | 8 | MAC transmit byte |
| tx_mac_last | output | 1 | Last byte of the frame |
| tx_mac_ready | input | 1 | MAC accepts byte |
| tx_sts_valid | output | 1 | Completion byte valid |
| tx_sts_data | output | 8 | Completion byte |
| tx_sts_last | output | 1 | Last completion byte |
| tx_sts_ready | input | 1 | DMA accepts completion byte |
| tx_status | output | 32 | Transmit status word |
| tx_sticky | output | 32 | Transmit sticky word |

## Verification
The bench goes after the padding arithmetic in three cases. A frame short enough to hit the 64-byte floor catches a design that drops the floor: it would give too short a buffer. A 61-byte frame needs alignment fill, so a design that skips the rounding gives a wrong byte count or ends `rx_buf_last` early. A frame larger than the store catches a design that wraps the store or drops the overflow flag: it would corrupt the data or report the wrong length. The status phase is checked both with and without checksum mode, where a wrong order or byte lane shows up as a swapped word. The bench also checks a zero transmit prefix and starts issued while disabled, where a careless design would still move bytes or flip its phase. Finally it checks re-enabling, which must clear only the complete bit and leave the sticky copy set.

// File: rtl/eth_fmt_pkg.sv
package eth_fmt_pkg;
   localparam int LEN_W = 16;
   localparam int STS_W = 32;

   localparam int RXB_ACCEPT = 16;
   localparam int RXB_COMP   = 17;
   localparam int RXB_OK     = 18;
   localparam int RXB_OVF    = 19;
   localparam int TXB_COMP   = 0;
   localparam int TXB_OK     = 1;

   typedef enum logic [1:0] {
      RX_IDLE, RX_COLLECT, RX_EMIT, RX_STS
   } rx_state_t;

   typedef enum logic [2:0] {
      TX_IDLE, TX_LEN0, TX_LEN1, TX_PASS, TX_STS
   } tx_state_t;

   function automatic logic [LEN_W-1:0] pad4(input logic [LEN_W-1:0] v);
      return (v + LEN_W'(3)) & ~LEN_W'(3);
   endfunction

   function automatic logic [LEN_W-1:0] report_len(input logic [LEN_W-1:0] n);
      logic [LEN_W-1:0] raw;
      raw = n + LEN_W'(8);
      return (raw < LEN_W'(64)) ? LEN_W'(64) : raw;
   endfunction
endpackage

// File: rtl/eth_rx_store.sv
module eth_rx_store
   import eth_fmt_pkg::*;
#(
   parameter int CAP_BYTES = 256,
   localparam int AW    = (CAP_BYTES > 1) ? $clog2(CAP_BYTES) : 1,
   localparam int CNT_W = $clog2(CAP_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic [LEN_W-1:0] rd_idx,
   output logic [7:0]       rd_data,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);
   logic [7:0] mem [CAP_BYTES];
   logic       room;

   assign room = (count < CNT_W'(CAP_BYTES));

   always_ff @(posedge clk) begin
      if (wr_en && room) mem[count[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst || clr) begin
         count <= '0;
         ovf   <= 1'b0;
      end else if (wr_en) begin
         if (room) count <= count + CNT_W'(1);
         else      ovf   <= 1'b1;
      end
   end

   assign rd_data = (rd_idx < LEN_W'(CAP_BYTES)) ? mem[rd_idx[AW-1:0]] : 8'h00;

   a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
      count <= CNT_W'(CAP_BYTES));

   a_r7_ovf_only_when_full: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !clr && !room) |=> ovf);
endmodule

// File: rtl/eth_rx_fmt.sv
module eth_rx_fmt
   import eth_fmt_pkg::*;
#(
   parameter int CAP_BYTES = 256,
   parameter bit CKS_EN    = 1'b1,
   localparam int CNT_W    = $clog2(CAP_BYTES + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rx_en,
   input  logic             cks_mode,
   input  logic [31:0]      rx_crc_in,
   input  logic             rx_start,
   output logic             rx_busy,
   input  logic             rx_mac_valid,
   input  logic [7:0]       rx_mac_data,
   input  logic             rx_mac_last,
   output logic             rx_mac_ready,
   output logic             rx_buf_valid,
   output logic [7:0]       rx_buf_data,
   output logic             rx_buf_last,
   input  logic             rx_buf_ready,
   output logic [STS_W-1:0] rx_status,
   output logic [STS_W-1:0] rx_sticky
);
   rx_state_t        state;
   logic             phase;
   logic             en_q;
   logic [LEN_W-1:0] emit_idx, len_q, tot_q;
   logic [2:0]       sts_idx;
   logic             cks_q;
   logic [31:0]      crc_q, sword_q;
   logic             cks_act;

   logic             st_clr, st_wr;
   logic [7:0]       st_rd_data;
   logic [CNT_W-1:0] st_count;
   logic             st_ovf;
   logic [LEN_W-1:0] data_idx, n_next, len_c;

   generate
      if (CKS_EN) begin : g_cks
         assign cks_act = cks_mode;
      end else begin : g_nocks
         assign cks_act = 1'b0;
      end
   endgenerate

   assign st_clr   = (state == RX_IDLE) && rx_start && rx_en && !phase;
   assign st_wr    = (state == RX_COLLECT) && rx_mac_valid;
   assign data_idx = emit_idx - LEN_W'(2);
   assign n_next   = LEN_W'(st_count) +
                     ((st_count < CNT_W'(CAP_BYTES)) ? LEN_W'(1) : LEN_W'(0));
   assign len_c    = report_len(n_next);

   eth_rx_store #(.CAP_BYTES(CAP_BYTES)) store_i (
      .clk    (clk),
      .rst    (rst),
      .clr    (st_clr),
      .wr_en  (st_wr),
      .wr_data(rx_mac_data),
      .rd_idx (data_idx),
      .rd_data(st_rd_data),
      .count  (st_count),
      .ovf    (st_ovf)
   );

   logic        frame_end, sts_end, sts_begin;
   logic [63:0] pair;
   logic [2:0]  sel;
   logic [2:0]  sts_final;

   assign pair      = {sword_q, crc_q};
   assign sel       = cks_q ? sts_idx : (sts_idx + 3'd4);
   assign sts_final = cks_q ? 3'd7 : 3'd3;

   always_comb begin
      rx_mac_ready = (state == RX_COLLECT);
      rx_buf_valid = 1'b0;
      rx_buf_data  = 8'h00;
      rx_buf_last  = 1'b0;
      case (state)
         RX_EMIT: begin
            rx_buf_valid = 1'b1;
            rx_buf_last  = (emit_idx == tot_q - LEN_W'(1));
            if (emit_idx == LEN_W'(0))      rx_buf_data = len_q[7:0];
            else if (emit_idx == LEN_W'(1)) rx_buf_data = len_q[15:8];
            else if (data_idx < LEN_W'(st_count)) rx_buf_data = st_rd_data;
         end
         RX_STS: begin
            rx_buf_valid = 1'b1;
            rx_buf_data  = pair[{sel, 3'b000} +: 8];
            rx_buf_last  = (sts_idx == sts_final);
         end
         default: ;
      endcase
   end

   assign frame_end = (state == RX_EMIT) && rx_buf_ready && rx_buf_last;
   assign sts_end   = (state == RX_STS) && rx_buf_ready && rx_buf_last;
   assign sts_begin = (state == RX_IDLE) && rx_start && phase;
   assign rx_busy   = (state != RX_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= RX_IDLE;
         phase    <= 1'b0;
         emit_idx <= '0;
         len_q    <= '0;
         tot_q    <= '0;
         sts_idx  <= '0;
         cks_q    <= 1'b0;
         crc_q    <= '0;
      end else begin
         case (state)
            RX_IDLE: begin
               if (st_clr) state <= RX_COLLECT;
               else if (sts_begin) begin
                  state   <= RX_STS;
                  sts_idx <= '0;
                  cks_q   <= cks_act;
                  crc_q   <= rx_crc_in;
               end
            end
            RX_COLLECT: begin
               if (rx_mac_valid && rx_mac_last) begin
                  state    <= RX_EMIT;
                  emit_idx <= '0;
                  len_q    <= len_c;
                  tot_q    <= LEN_W'(2) + pad4(len_c);
               end
            end
            RX_EMIT: begin
               if (rx_buf_ready) begin
                  emit_idx <= emit_idx + LEN_W'(1);
                  if (rx_buf_last) begin
                     state <= RX_IDLE;
                     phase <= 1'b1;
                  end
               end
            end
            RX_STS: begin
               if (rx_buf_ready) begin
                  sts_idx <= sts_idx + 3'd1;
                  if (rx_buf_last) begin
                     state <= RX_IDLE;
                     phase <= 1'b0;
                  end
               end
            end
            default: state <= RX_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rx_status <= '0;
         rx_sticky <= '0;
         en_q      <= 1'b0;
         sword_q   <= '0;
      end else begin
         en_q <= rx_en;
         if (rx_en && !en_q) rx_status[RXB_COMP] <= 1'b0;
         if (frame_end) begin
            rx_status[LEN_W-1:0]  <= len_q;
            rx_status[RXB_ACCEPT] <= 1'b1;
            rx_status[RXB_COMP]   <= 1'b1;
            rx_status[RXB_OVF]    <= st_ovf;
            rx_sticky[RXB_ACCEPT] <= 1'b1;
            rx_sticky[RXB_COMP]   <= 1'b1;
            if (st_ovf) rx_sticky[RXB_OVF] <= 1'b1;
         end
         if (sts_begin) begin
            rx_status[RXB_OK] <= 1'b1;
            rx_sticky[RXB_OK] <= 1'b1;
            sword_q           <= rx_status | (32'd1 << RXB_OK);
         end
      end
   end

   a_r2_last_has_valid: assert property (@(posedge clk) disable iff (rst)
      rx_buf_last |-> rx_buf_valid);

   a_r2_hold_while_stalled: assert property (@(posedge clk) disable iff (rst)
      (rx_buf_valid && !rx_buf_ready) |=> (rx_buf_valid && $stable(rx_buf_data)));

   a_r3_disabled_start: assert property (@(posedge clk) disable iff (rst)
      ((state == RX_IDLE) && rx_start && !rx_en && !phase) |=> !rx_busy);

   a_r6_phase_moves_at_end: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((phase == $past(phase)) || $past(frame_end || sts_end)));

   a_r4_sticky_monotonic: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (($past(rx_sticky) & ~rx_sticky) == '0));

   a_r1_len_floor: assert property (@(posedge clk) disable iff (rst)
      (state == RX_EMIT) |-> (len_q >= LEN_W'(64)));
endmodule

// File: rtl/eth_tx_fmt.sv
module eth_tx_fmt
   import eth_fmt_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             tx_en,
   input  logic             tx_start,
   output logic             tx_busy,
   input  logic             tx_buf_valid,
   input  logic [7:0]       tx_buf_data,
   output logic             tx_buf_ready,
   output logic             tx_mac_valid,
   output logic [7:0]       tx_mac_data,
   output logic             tx_mac_last,
   input  logic             tx_mac_ready,
   output logic             tx_sts_valid,
   output logic [7:0]       tx_sts_data,
   output logic             tx_sts_last,
   input  logic             tx_sts_ready,
   output logic [STS_W-1:0] tx_status,
   output logic [STS_W-1:0] tx_sticky
);
   tx_state_t        state;
   logic             phase;
   logic             en_q;
   logic [7:0]       len_lo;
   logic [LEN_W-1:0] rem;
   logic [1:0]       sts_idx;
   logic [31:0]      sword_q;
   logic             pass_end, sts_begin, sts_end;

   always_comb begin
      tx_buf_ready = 1'b0;
      tx_mac_valid = 1'b0;
      tx_mac_data  = 8'h00;
      tx_mac_last  = 1'b0;
      tx_sts_valid = 1'b0;
      tx_sts_data  = 8'h00;
      tx_sts_last  = 1'b0;
      case (state)
         TX_LEN0, TX_LEN1: tx_buf_ready = 1'b1;
         TX_PASS: begin
            tx_mac_valid = tx_buf_valid;
            tx_mac_data  = tx_buf_data;
            tx_mac_last  = tx_buf_valid && (rem == LEN_W'(1));
            tx_buf_ready = tx_mac_ready;
         end
         TX_STS: begin
            tx_sts_valid = 1'b1;
            tx_sts_data  = sword_q[{sts_idx, 3'b000} +: 8];
            tx_sts_last  = (sts_idx == 2'd3);
         end
         default: ;
      endcase
   end

   assign pass_end  = (state == TX_PASS) && tx_buf_valid && tx_mac_ready &&
                      (rem == LEN_W'(1));
   assign sts_begin = (state == TX_IDLE) && tx_start && phase;
   assign sts_end   = (state == TX_STS) && tx_sts_ready && tx_sts_last;
   assign tx_busy   = (state != TX_IDLE);

   always_ff @(posedge clk) begin
      if (rst) begin
         state   <= TX_IDLE;
         phase   <= 1'b0;
         len_lo  <= '0;
         rem     <= '0;
         sts_idx <= '0;
      end else begin
         case (state)
            TX_IDLE: begin
               if (tx_start && !phase && tx_en) state <= TX_LEN0;
               else if (sts_begin) begin
                  state   <= TX_STS;
                  sts_idx <= '0;
               end
            end
            TX_LEN0: if (tx_buf_valid) begin
               len_lo <= tx_buf_data;
               state  <= TX_LEN1;
            end
            TX_LEN1: if (tx_buf_valid) begin
               rem <= {tx_buf_data, len_lo};
               if ({tx_buf_data, len_lo} == '0) state <= TX_IDLE;
               else                             state <= TX_PASS;
            end
            TX_PASS: if (tx_buf_valid && tx_mac_ready) begin
               rem <= rem - LEN_W'(1);
               if (pass_end) begin
                  state <= TX_IDLE;
                  phase <= 1'b1;
               end
            end
            TX_STS: if (tx_sts_ready) begin
               sts_idx <= sts_idx + 2'd1;
               if (tx_sts_last) begin
                  state <= TX_IDLE;
                  phase <= 1'b0;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_status <= '0;
         tx_sticky <= '0;
         en_q      <= 1'b0;
         sword_q   <= '0;
      end else begin
         en_q <= tx_en;
         if (tx_en && !en_q) tx_status[TXB_COMP] <= 1'b0;
         if (pass_end) begin
            tx_status[TXB_COMP] <= 1'b1;
            tx_sticky[TXB_COMP] <= 1'b1;
         end
         if (sts_begin) begin
            tx_status[TXB_OK] <= 1'b1;
            tx_sticky[TXB_OK] <= 1'b1;
            sword_q           <= tx_status | (32'd1 << TXB_OK);
         end
      end
   end

   a_r9_mac_valid_from_dma: assert property (@(posedge clk) disable iff (rst)
      tx_mac_valid |-> tx_buf_valid);

   a_r8_zero_prefix_idle: assert property (@(posedge clk) disable iff (rst)
      ((state == TX_LEN1) && tx_buf_valid && (tx_buf_data == 8'h00) &&
       (len_lo == 8'h00)) |=> (!tx_busy && $stable(tx_status)));

   a_r10_sts_last_has_valid: assert property (@(posedge clk) disable iff (rst)
      tx_sts_last |-> tx_sts_valid);

   a_r6_tx_phase_moves_at_end: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((phase == $past(phase)) || $past(pass_end || sts_end)));

   a_r9_sticky_monotonic: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (($past(tx_sticky) & ~tx_sticky) == '0));
endmodule

// File: rtl/eth_dmabuf_fmt.sv
module eth_dmabuf_fmt
   import eth_fmt_pkg::*;
#(
   parameter int CAP_BYTES = 256,
   parameter bit CKS_EN    = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        rx_en,
   input  logic        cks_mode,
   input  logic [31:0] rx_crc_in,
   input  logic        rx_start,
   output logic        rx_busy,
   input  logic        rx_mac_valid,
   input  logic [7:0]  rx_mac_data,
   input  logic        rx_mac_last,
   output logic        rx_mac_ready,
   output logic        rx_buf_valid,
   output logic [7:0]  rx_buf_data,
   output logic        rx_buf_last,
   input  logic        rx_buf_ready,
   output logic [31:0] rx_status,
   output logic [31:0] rx_sticky,
   input  logic        tx_en,
   input  logic        tx_start,
   output logic        tx_busy,
   input  logic        tx_buf_valid,
   input  logic [7:0]  tx_buf_data,
   output logic        tx_buf_ready,
   output logic        tx_mac_valid,
   output logic [7:0]  tx_mac_data,
   output logic        tx_mac_last,
   input  logic        tx_mac_ready,
   output logic        tx_sts_valid,
   output logic [7:0]  tx_sts_data,
   output logic        tx_sts_last,
   input  logic        tx_sts_ready,
   output logic [31:0] tx_status,
   output logic [31:0] tx_sticky
);
   generate
      if (CAP_BYTES < 4) begin : g_cap_small
         $error("CAP_BYTES must be at least 4");
      end
      if (CAP_BYTES + 16 >= (1 << LEN_W)) begin : g_cap_large
         $error("CAP_BYTES does not fit the length prefix");
      end
   endgenerate

   eth_rx_fmt #(.CAP_BYTES(CAP_BYTES), .CKS_EN(CKS_EN)) rx_i (
      .clk         (clk),
      .rst         (rst),
      .rx_en       (rx_en),
      .cks_mode    (cks_mode),
      .rx_crc_in   (rx_crc_in),
      .rx_start    (rx_start),
      .rx_busy     (rx_busy),
      .rx_mac_valid(rx_mac_valid),
      .rx_mac_data (rx_mac_data),
      .rx_mac_last (rx_mac_last),
      .rx_mac_ready(rx_mac_ready),
      .rx_buf_valid(rx_buf_valid),
      .rx_buf_data (rx_buf_data),
      .rx_buf_last (rx_buf_last),
      .rx_buf_ready(rx_buf_ready),
      .rx_status   (rx_status),
      .rx_sticky   (rx_sticky)
   );

   eth_tx_fmt tx_i (
      .clk         (clk),
      .rst         (rst),
      .tx_en       (tx_en),
      .tx_start    (tx_start),
      .tx_busy     (tx_busy),
      .tx_buf_valid(tx_buf_valid),
      .tx_buf_data (tx_buf_data),
      .tx_buf_ready(tx_buf_ready),
      .tx_mac_valid(tx_mac_valid),
      .tx_mac_data (tx_mac_data),
      .tx_mac_last (tx_mac_last),
      .tx_mac_ready(tx_mac_ready),
      .tx_sts_valid(tx_sts_valid),
      .tx_sts_data (tx_sts_data),
      .tx_sts_last (tx_sts_last),
      .tx_sts_ready(tx_sts_ready),
      .tx_status   (tx_status),
      .tx_sticky   (tx_sticky)
   );

   a_r12_idle_no_output: assert property (@(posedge clk) disable iff (rst)
      (!rx_busy |-> !rx_buf_valid) and (!tx_busy |-> !(tx_mac_valid || tx_sts_valid)));
endmodule

// File: tb/eth_dmabuf_fmt_tb_top.sv
module eth_dmabuf_fmt_tb_top;
   localparam int CAP = 256;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic rx_en = 1'b0, cks_mode = 1'b0, rx_start = 1'b0;
   logic [31:0] rx_crc_in = '0;
   logic rx_busy, rx_mac_valid = 1'b0, rx_mac_last = 1'b0, rx_mac_ready;
   logic [7:0] rx_mac_data = '0;
   logic rx_buf_valid, rx_buf_last, rx_buf_ready = 1'b1;
   logic [7:0] rx_buf_data;
   logic [31:0] rx_status, rx_sticky, tx_status, tx_sticky;
   logic tx_en = 1'b0, tx_start = 1'b0, tx_busy;
   logic tx_buf_valid = 1'b0, tx_buf_ready;
   logic [7:0] tx_buf_data = '0;
   logic tx_mac_valid, tx_mac_last, tx_mac_ready = 1'b1;
   logic [7:0] tx_mac_data, tx_sts_data;
   logic tx_sts_valid, tx_sts_last, tx_sts_ready = 1'b1;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [31:0] m_rxs = '0, m_rxk = '0, m_txs = '0, m_txk = '0;
   logic [7:0] cap [600];
   int cap_n;
   logic [7:0] mac_cap [64];
   int mac_n;
   int mac_last_at;

   always #2 clk = ~clk;

   eth_dmabuf_fmt #(.CAP_BYTES(CAP), .CKS_EN(1'b1)) dut_i (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse_rx();
      rx_start = 1'b1; @(negedge clk); rx_start = 1'b0;
   endtask

   task automatic pulse_tx();
      tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
   endtask

   task automatic mac_byte(input logic [7:0] d, input logic l);
      rx_mac_valid = 1'b1; rx_mac_data = d; rx_mac_last = l;
      #1;
      while (!rx_mac_ready) begin @(negedge clk); #1; end
      @(negedge clk);
      rx_mac_valid = 1'b0; rx_mac_last = 1'b0;
   endtask

   // sel 0: receive buffer stream, sel 1: transmit completion stream
   task automatic read_stream(input bit sel);
      cap_n = 0;
      for (int g = 0; g < 2000; g++) begin
         #1;
         if (sel ? tx_sts_valid : rx_buf_valid) begin
            cap[cap_n] = sel ? tx_sts_data : rx_buf_data;
            cap_n++;
            if (sel ? tx_sts_last : rx_buf_last) break;
         end
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   task automatic buf_byte(input logic [7:0] d);
      tx_buf_valid = 1'b1; tx_buf_data = d;
      #1;
      while (!tx_buf_ready) begin @(negedge clk); #1; end
      if (tx_mac_valid) begin
         mac_cap[mac_n] = tx_mac_data;
         if (tx_mac_last) mac_last_at = mac_n;
         mac_n++;
      end
      @(negedge clk);
      tx_buf_valid = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((seed + i * 7) & 255);
   endfunction

   task automatic rx_test(input string tag, input int nin, input int seed,
                          input bit cks, input logic [31:0] crc);
      int n, len, tot, bad;
      logic [31:0] w;
      n   = (nin > CAP) ? CAP : nin;
      len = (n + 8 < 64) ? 64 : n + 8;
      tot = 2 + ((len + 3) & ~3);
      cks_mode = cks; rx_crc_in = crc;
      pulse_rx();
      for (int i = 0; i < nin; i++) mac_byte(pat(seed, i), (i == nin - 1));
      read_stream(1'b0);
      chk({tag, " R2 byte count"}, cap_n, tot);
      chk({tag, " R1 length prefix"}, {16'h0, cap[1], cap[0]}, len);
      bad = 0;
      for (int i = 0; i < tot - 2; i++)
         if (cap[i + 2] !== ((i < n) ? pat(seed, i) : 8'h00)) bad++;
      chk({tag, " R2 data and fill"}, bad, 0);
      m_rxs[15:0] = 16'(len); m_rxs[16] = 1'b1; m_rxs[17] = 1'b1;
      m_rxs[19] = (nin > CAP);
      m_rxk[16] = 1'b1; m_rxk[17] = 1'b1; if (nin > CAP) m_rxk[19] = 1'b1;
      chk({tag, " R4 R7 status after frame"}, rx_status, m_rxs);
      chk({tag, " R4 R7 sticky after frame"}, rx_sticky, m_rxk);
      // R6: the next start opens the status phase, not a new frame
      pulse_rx();
      read_stream(1'b0);
      m_rxs[18] = 1'b1; m_rxk[18] = 1'b1;
      chk({tag, " R5 R6 status phase length"}, cap_n, cks ? 8 : 4);
      if (cks) begin
         w = {cap[3], cap[2], cap[1], cap[0]};
         chk({tag, " R5 checksum word"}, w, crc);
         w = {cap[7], cap[6], cap[5], cap[4]};
      end else w = {cap[3], cap[2], cap[1], cap[0]};
      chk({tag, " R5 status word"}, w, m_rxs);
      chk({tag, " R5 sticky ok"}, rx_sticky, m_rxk);
   endtask

   task automatic rx_disabled_test();
      int seen;
      rx_en = 1'b0;
      @(negedge clk); @(negedge clk);
      pulse_rx();
      seen = 0;
      for (int i = 0; i < 5; i++) begin
         if (rx_busy || rx_buf_valid || rx_mac_ready) seen++;
         @(negedge clk);
      end
      chk("R3 rx start ignored while disabled", seen, 0);
      rx_en = 1'b1;
      @(negedge clk); @(negedge clk);
      m_rxs[17] = 1'b0;
      chk("R11 rx enable edge clears complete", rx_status, m_rxs);
      chk("R11 rx sticky kept", rx_sticky, m_rxk);
   endtask

   task automatic tx_zero_test();
      tx_en = 1'b1; mac_n = 0; mac_last_at = -1;
      @(negedge clk);
      pulse_tx();
      buf_byte(8'h00); buf_byte(8'h00);
      chk("R8 zero prefix sends nothing", mac_n, 0);
      chk("R8 zero prefix leaves idle", tx_busy, 0);
      chk("R8 zero prefix status unchanged", tx_status, m_txs);
      chk("R8 zero prefix sticky unchanged", tx_sticky, m_txk);
   endtask

   task automatic tx_frame_test(input int len);
      int bad;
      mac_n = 0; mac_last_at = -1;
      // R6: phase stayed at frame after the zero prefix, so this is a frame
      pulse_tx();
      buf_byte(8'(len)); buf_byte(8'(len >> 8));
      for (int i = 0; i < len; i++) buf_byte(pat(9, i));
      chk("R9 bytes forwarded", mac_n, len);
      chk("R9 last on final byte", mac_last_at, len - 1);
      bad = 0;
      for (int i = 0; i < mac_n; i++) if (mac_cap[i] !== pat(9, i)) bad++;
      chk("R9 forwarded data", bad, 0);
      #1;
      chk("R9 no extra byte taken", tx_buf_ready, 0);
      m_txs[0] = 1'b1; m_txk[0] = 1'b1;
      chk("R9 complete status", tx_status, m_txs);
      chk("R9 complete sticky", tx_sticky, m_txk);
      pulse_tx();
      read_stream(1'b1);
      m_txs[1] = 1'b1; m_txk[1] = 1'b1;
      chk("R10 R6 completion length", cap_n, 4);
      chk("R10 completion word", {cap[3], cap[2], cap[1], cap[0]}, m_txs);
      chk("R10 ok sticky", tx_sticky, m_txk);
   endtask

   task automatic tx_disabled_test();
      int seen;
      tx_en = 1'b0;
      @(negedge clk); @(negedge clk);
      pulse_tx();
      seen = 0;
      for (int i = 0; i < 5; i++) begin
         if (tx_busy || tx_buf_ready || tx_mac_valid || tx_sts_valid) seen++;
         @(negedge clk);
      end
      chk("R3 tx start ignored while disabled", seen, 0);
      tx_en = 1'b1;
      @(negedge clk); @(negedge clk);
      m_txs[0] = 1'b0;
      chk("R11 tx enable edge clears complete", tx_status, m_txs);
      chk("R11 tx sticky kept", tx_sticky, m_txk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R12 reset rx status", rx_status, 0);
      chk("R12 reset rx sticky", rx_sticky, 0);
      chk("R12 reset tx status", tx_status, 0);
      chk("R12 reset tx sticky", tx_sticky, 0);
      chk("R12 reset idle", {rx_busy, tx_busy, rx_buf_valid, tx_mac_valid, tx_sts_valid}, 0);
      rx_en = 1'b1;
      @(negedge clk);
      rx_test("short", 10, 3, 1'b0, 32'h0);
      rx_test("align", 61, 17, 1'b1, 32'hA1B2C3D4);
      rx_test("overflow", 300, 5, 1'b0, 32'h0);
      rx_disabled_test();
      rx_test("large", 120, 40, 1'b1, 32'h01234567);
      tx_zero_test();
      tx_frame_test(5);
      tx_disabled_test();
      tx_frame_test(37);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule